// File: doc/BRIEF.md
# Hashed Page Table Group Search Engine

This engine resolves one address translation against a hashed page table kept in memory. The caller supplies the segment descriptor, the privilege level, the kind of access, the compare tag and the base byte addresses of the primary and secondary entry groups. The hash that yields those bases is computed outside. A one-cycle `start` pulse latches all of these. The engine then reads entries through a simple request/valid memory port. It compares each entry's first word against the tag. Only for a hit does it fetch the second word, and from that word it derives read, write and execute rights.

The primary group is always searched first. The secondary group is searched only when the primary search does not grant the access. A hit in the secondary group, whether it grants or denies, replaces the primary outcome. A miss in the secondary group leaves the primary outcome in place. Two kinds of access never touch memory: a direct-store segment, and an instruction fetch from a segment marked no-execute.

When the search ends, `done` pulses for one cycle. At that moment the outputs hold a result code, the second word of the deciding entry and a three-bit rights vector. All three remain stable until the next search starts.

Top module: `pte_group_search`

## Requirements
- R1: A `start` pulse in idle latches every request input. `done` later rises for exactly one cycle. `start` while a search is running is ignored and does not change that search's result.
- R2: `memReq` stays high with a stable `memAddr` until `memValid` is seen in the same cycle, and `memData` is taken in that cycle. `memReq` is low after reset and while idle.
- R3: With `mode64`=0 an entry occupies 8 bytes: the first word is at +0 and the second at +4. Only `memData[31:0]` is used and `pteWord[63:32]` reads 0. With `mode64`=1 an entry occupies 16 bytes: the words are at +0 and +8, and all 64 bits are used. Entry i of a group is at base + i*stride.
- R4: A first word matches when three conditions hold: its valid bit (bit 31 in 32-bit mode, bit 63 in 64-bit mode) is set, its bit 0 equals the group being searched (0 primary, 1 secondary), and bits [24:1] equal `cmpTag`. Each group has 8 entries. The second word is read only for a match, and the first match ends that group.
- R5: The secondary group is searched only when the primary search ends without a grant. A secondary match replaces the primary outcome. A secondary miss keeps it.
- R6: The key is 1 when `segDesc[29]` is set with `userMode`=1, or `segDesc[30]` is set with `userMode`=0. Otherwise it is 0. The protection value is `{mode64 & w[63], w[1:0]}` of the second word w.
- R7: With key 0, protection values 0, 1 and 2 give read and write, 3 and 6 give read only, and 4, 5 and 7 give nothing. With key 1, values 2 gives read and write, 1 and 3 give read only, and 0, 4, 5, 6 and 7 give nothing.
- R8: `prot` bit 0 is read, bit 1 is write and bit 2 is execute. Execute is set only when the no-execute flag is 0. That flag is `segDesc[28]` ORed, in 64-bit mode only, with bits 2 and 3 of the second word.
- R9: `accKind` takes four values. 0 and 3 are loads and need read. 1 is a store and needs write. 2 is a fetch and needs execute. `resCode` is 00 for a grant, 10 for a denial and 11 for no match.
- R10: When `segDesc[31]` is set, no memory read happens and the result is code 01 with `pteWord`=0 and `prot`=0. This takes priority over R11.
- R11: A fetch (`accKind`=2) with `segDesc[28]` set makes no memory read and yields code 10 with `pteWord`=0 and `prot`=0.
- R12: With no match in either group, the result is code 11 with `pteWord`=0 and `prot`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a search (ignored while busy) |
| segDesc | input | 32 | Segment descriptor |
| userMode | input | 1 | 1 = user privilege, 0 = supervisor |
| accKind | input | 2 | 0 load, 1 store, 2 fetch, 3 load |
| mode64 | input | 1 | Entry format: 1 = 64-bit, 0 = 32-bit |
| priBase | input | ADDR_W | Byte address of primary group |
| secBase | input | ADDR_W | Byte address of secondary group |
| cmpTag | input | TAG_W | Tag to compare against entries |
| memReq | output | 1 | Memory read request |
| memAddr | output | ADDR_W | Memory read byte address |
| memValid | input | 1 | Read data valid |
| memData | input | 64 | Read data |
| done | output | 1 | One-cycle end-of-search pulse |
| resCode | output | 2 | Result code |
| pteWord | output | 64 | Second word of deciding entry |
| prot | output | 3 | Rights: X, W, R |

## Verification
The assertions assume that the memory port answers every request eventually. They also assume that `memValid` is meaningful only while `memReq` is high, and that `start` arrives as a pulse. The bench's memory model raises `memValid` one cycle after a request. It drops `memValid` in the following cycle, so a single request is never answered twice. Every group is filled with decoy entries: some with a wrong tag, some with the wrong hash-select bit, and some with the valid bit cleared. This forces each rejection path in the tag compare to be exercised while the handshake stays within that contract.

// File: rtl/pte_search_pkg.sv
package pte_search_pkg;

  localparam logic [1:0] RES_GRANT  = 2'b00;
  localparam logic [1:0] RES_BYPASS = 2'b01;
  localparam logic [1:0] RES_DENY   = 2'b10;
  localparam logic [1:0] RES_MISS   = 2'b11;

  localparam logic [1:0] KIND_LOAD  = 2'd0;
  localparam logic [1:0] KIND_STORE = 2'd1;
  localparam logic [1:0] KIND_FETCH = 2'd2;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic skipDs;
    logic skipNx;
    logic wordSel;
    logic ldWord0;
    logic ldWord1;
    logic record;
    logic nextEntry;
    logic toSecondary;
  } ctlStrobes_t;

endpackage

// File: rtl/pte_search_dp.sv
module pte_search_dp
  import pte_search_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int TAG_W = 24,
  parameter int GROUP_ENTRIES = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       ctl,
  input  logic [31:0]       segDesc,
  input  logic              userMode,
  input  logic [1:0]        accKind,
  input  logic              mode64,
  input  logic [ADDR_W-1:0] priBase,
  input  logic [ADDR_W-1:0] secBase,
  input  logic [TAG_W-1:0]  cmpTag,
  input  logic [63:0]       memData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              rawDs,
  output logic              rawNxFetch,
  output logic              tagHit,
  output logic              lastEntry,
  output logic              onSecondary,
  output logic              granted,
  output logic [1:0]        resCode,
  output logic [63:0]       pteWord,
  output logic [2:0]        prot
);
  localparam int IDX_W = (GROUP_ENTRIES > 1) ? $clog2(GROUP_ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(GROUP_ENTRIES - 1);

  logic [31:0]       segReg;
  logic              userReg, m64Reg;
  logic [1:0]        kindReg;
  logic [ADDR_W-1:0] priReg, secReg;
  logic [TAG_W-1:0]  tagReg;
  logic [IDX_W-1:0]  idx;
  logic              grpSec;
  logic [63:0]       word0, word1;

  assign rawDs      = segDesc[31];
  assign rawNxFetch = segDesc[28] && (accKind == KIND_FETCH);

  // address generation
  logic [ADDR_W-1:0] grpBase, entryOff, halfOff;
  always_comb begin
    grpBase  = grpSec ? secReg : priReg;
    entryOff = m64Reg ? (ADDR_W'(idx) << 4) : (ADDR_W'(idx) << 3);
    halfOff  = ctl.wordSel ? (m64Reg ? ADDR_W'(8) : ADDR_W'(4)) : '0;
    memAddr  = grpBase + entryOff + halfOff;
  end

  // first-word compare
  logic validBit;
  assign validBit    = m64Reg ? word0[63] : word0[31];
  assign tagHit      = validBit && (word0[0] == grpSec) && (word0[TAG_W:1] == tagReg);
  assign lastEntry   = (idx == LAST_IDX);
  assign onSecondary = grpSec;

  // rights derivation
  logic [2:0] ppVal;
  logic       keyBit, noExec, rdOk, wrOk;
  logic [2:0] rights;
  always_comb begin
    keyBit = (segReg[29] && userReg) || (segReg[30] && !userReg);
    ppVal  = {m64Reg && word1[63], word1[1:0]};
    noExec = segReg[28] || (m64Reg && (word1[2] || word1[3]));
    rdOk = 1'b0;
    wrOk = 1'b0;
    if (!keyBit) begin
      case (ppVal)
        3'd0, 3'd1, 3'd2: begin rdOk = 1'b1; wrOk = 1'b1; end
        3'd3, 3'd6:       rdOk = 1'b1;
        default: ;
      endcase
    end else begin
      case (ppVal)
        3'd2:       begin rdOk = 1'b1; wrOk = 1'b1; end
        3'd1, 3'd3: rdOk = 1'b1;
        default: ;
      endcase
    end
    rights = {!noExec, wrOk, rdOk};
    case (kindReg)
      KIND_FETCH: granted = rights[2];
      KIND_STORE: granted = rights[1];
      default:    granted = rights[0];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      segReg <= '0; userReg <= 1'b0; kindReg <= '0; m64Reg <= 1'b0;
      priReg <= '0; secReg <= '0; tagReg <= '0;
      idx <= '0; grpSec <= 1'b0; word0 <= '0; word1 <= '0;
      resCode <= RES_MISS; pteWord <= '0; prot <= '0;
    end else begin
      if (ctl.capture) begin
        segReg <= segDesc; userReg <= userMode; kindReg <= accKind;
        m64Reg <= mode64; priReg <= priBase; secReg <= secBase;
        tagReg <= cmpTag; idx <= '0; grpSec <= 1'b0;
        pteWord <= '0; prot <= '0;
        resCode <= ctl.skipDs ? RES_BYPASS : (ctl.skipNx ? RES_DENY : RES_MISS);
      end
      if (ctl.ldWord0) word0 <= m64Reg ? memData : {32'b0, memData[31:0]};
      if (ctl.ldWord1) word1 <= m64Reg ? memData : {32'b0, memData[31:0]};
      if (ctl.nextEntry) idx <= idx + 1'b1;
      if (ctl.toSecondary) begin
        grpSec <= 1'b1;
        idx    <= '0;
      end
      if (ctl.record) begin
        resCode <= granted ? RES_GRANT : RES_DENY;
        pteWord <= word1;
        prot    <= rights;
      end
    end
  end

  // a grant result always carries the right its access kind needs
  assert_grant_right_R9: assert property (@(posedge clk) disable iff (!rstN)
    (resCode == RES_GRANT) |->
      ((kindReg == KIND_FETCH) ? prot[2] : (kindReg == KIND_STORE) ? prot[1] : prot[0]));

  // no-match leaves empty outputs
  assert_miss_empty_R12: assert property (@(posedge clk) disable iff (!rstN)
    (resCode == RES_MISS) |-> (pteWord == '0 && prot == '0));

  // 32-bit results never carry upper bits
  assert_word32_R3: assert property (@(posedge clk) disable iff (!rstN)
    !m64Reg |-> (pteWord[63:32] == '0));

  // the search only returns to the primary group on a new request
  assert_group_order_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(grpSec) |-> $past(ctl.capture));

endmodule

// File: rtl/pte_search_ctrl.sv
module pte_search_ctrl
  import pte_search_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        rawDs,
  input  logic        rawNxFetch,
  input  logic        memValid,
  input  logic        tagHit,
  input  logic        lastEntry,
  input  logic        onSecondary,
  input  logic        granted,
  output ctlStrobes_t ctl,
  output logic        memReq,
  output logic        done
);
  typedef enum logic [2:0] {S_IDLE, S_WORD0, S_TAG, S_WORD1, S_RIGHTS} state_t;
  state_t state, nxt;
  logic finish;

  always_comb begin
    ctl    = '0;
    nxt    = state;
    finish = 1'b0;
    case (state)
      S_IDLE: if (start) begin
        ctl.capture = 1'b1;
        if (rawDs) begin
          ctl.skipDs = 1'b1;
          finish = 1'b1;
        end else if (rawNxFetch) begin
          ctl.skipNx = 1'b1;
          finish = 1'b1;
        end else begin
          nxt = S_WORD0;
        end
      end
      S_WORD0: if (memValid) begin
        ctl.ldWord0 = 1'b1;
        nxt = S_TAG;
      end
      S_TAG: begin
        if (tagHit) begin
          nxt = S_WORD1;
        end else if (!lastEntry) begin
          ctl.nextEntry = 1'b1;
          nxt = S_WORD0;
        end else if (!onSecondary) begin
          ctl.toSecondary = 1'b1;
          nxt = S_WORD0;
        end else begin
          finish = 1'b1;
        end
      end
      S_WORD1: begin
        ctl.wordSel = 1'b1;
        if (memValid) begin
          ctl.ldWord1 = 1'b1;
          nxt = S_RIGHTS;
        end
      end
      S_RIGHTS: begin
        ctl.record = 1'b1;
        if (granted || onSecondary) begin
          finish = 1'b1;
        end else begin
          ctl.toSecondary = 1'b1;
          nxt = S_WORD0;
        end
      end
      default: nxt = S_IDLE;
    endcase
    if (finish) nxt = S_IDLE;
  end

  assign memReq = (state == S_WORD0) || (state == S_WORD1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      done  <= 1'b0;
    end else begin
      state <= nxt;
      done  <= finish;
    end
  end

  assert_done_pulse_R1: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memValid) |=> memReq);

  assert_no_lookup_R10: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && start && (rawDs || rawNxFetch)) |=> (done && !memReq));

endmodule

// File: rtl/pte_group_search.sv
module pte_group_search
  import pte_search_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int TAG_W = 24,
  parameter int GROUP_ENTRIES = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [31:0]       segDesc,
  input  logic              userMode,
  input  logic [1:0]        accKind,
  input  logic              mode64,
  input  logic [ADDR_W-1:0] priBase,
  input  logic [ADDR_W-1:0] secBase,
  input  logic [TAG_W-1:0]  cmpTag,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memValid,
  input  logic [63:0]       memData,
  output logic              done,
  output logic [1:0]        resCode,
  output logic [63:0]       pteWord,
  output logic [2:0]        prot
);
  ctlStrobes_t ctl;
  logic rawDs, rawNxFetch, tagHit, lastEntry, onSecondary, granted;

  pte_search_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .rawDs(rawDs), .rawNxFetch(rawNxFetch), .memValid(memValid),
    .tagHit(tagHit), .lastEntry(lastEntry), .onSecondary(onSecondary),
    .granted(granted), .ctl(ctl), .memReq(memReq), .done(done)
  );

  pte_search_dp #(.ADDR_W(ADDR_W), .TAG_W(TAG_W), .GROUP_ENTRIES(GROUP_ENTRIES)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .segDesc(segDesc), .userMode(userMode), .accKind(accKind), .mode64(mode64),
    .priBase(priBase), .secBase(secBase), .cmpTag(cmpTag), .memData(memData),
    .memAddr(memAddr), .rawDs(rawDs), .rawNxFetch(rawNxFetch), .tagHit(tagHit),
    .lastEntry(lastEntry), .onSecondary(onSecondary), .granted(granted),
    .resCode(resCode), .pteWord(pteWord), .prot(prot)
  );

  // address held while a request waits
  assert_addr_stable_R2: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memValid) |=> $stable(memAddr));

endmodule

// File: tb/tb_pte_group_search.sv
`timescale 1ns/1ps
module tb_pte_group_search;
  localparam real CLK_NS = 4.0;
  localparam logic [31:0] PRI_BASE = 32'h0000_1000;
  localparam logic [31:0] SEC_BASE = 32'h0000_2000;
  localparam logic [23:0] TAG = 24'hABCDE5;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0;
  logic [31:0] segDesc = '0;
  logic userMode = 1'b0, mode64 = 1'b0, memValid = 1'b0;
  logic [1:0] accKind = '0;
  logic [31:0] memAddr;
  logic [63:0] memData = '0, pteWord;
  logic memReq, done;
  logic [1:0] resCode;
  logic [2:0] prot;

  always #(CLK_NS/2) clk = ~clk;

  pte_group_search dut (
    .clk(clk), .rstN(rstN), .start(start), .segDesc(segDesc), .userMode(userMode),
    .accKind(accKind), .mode64(mode64), .priBase(PRI_BASE), .secBase(SEC_BASE),
    .cmpTag(TAG), .memReq(memReq), .memAddr(memAddr), .memValid(memValid),
    .memData(memData), .done(done), .resCode(resCode), .pteWord(pteWord), .prot(prot)
  );

  // scenario seen by the memory model
  logic curM64 = 1'b0;
  int curPHit = 8, curSHit = 8;
  logic [63:0] curPW1 = '0, curSW1 = '0;
  int reads = 0, nTests = 0, nFail = 0;

  function automatic logic [63:0] memRead(input logic [31:0] a);
    logic g, hi;
    logic [31:0] off;
    int stride, idx, hitIdx;
    logic [63:0] vbit, match0, w0, w1, w;
    g = (a >= SEC_BASE);
    off = a - (g ? SEC_BASE : PRI_BASE);
    stride = curM64 ? 16 : 8;
    idx = int'(off) / stride;
    hi = (int'(off) % stride) != 0;
    hitIdx = g ? curSHit : curPHit;
    vbit = curM64 ? 64'h8000_0000_0000_0000 : 64'h0000_0000_8000_0000;
    match0 = {39'b0, TAG, 1'b0} | {63'b0, g};
    w1 = '0;
    if (idx == hitIdx) begin
      w0 = vbit | match0;
      w1 = g ? curSW1 : curPW1;
    end else begin
      case (idx % 3)
        0: w0 = vbit | {39'b0, TAG ^ 24'h1, 1'b0} | {63'b0, g};
        1: w0 = vbit | {39'b0, TAG, 1'b0} | {63'b0, !g};
        default: w0 = match0;
      endcase
    end
    w = hi ? w1 : w0;
    return curM64 ? w : {32'hFFFF_FFFF, w[31:0]};
  endfunction

  // one-cycle-latency memory answering each request once
  always @(posedge clk) begin
    if (memReq && memValid) reads <= reads + 1;
    memValid <= memReq && !memValid;
    memData  <= memRead(memAddr);
  end

  task automatic check(input logic ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic launch(input logic m64, input logic [31:0] seg, input logic usr,
                        input logic [1:0] kind, input int ph, input logic [63:0] pw,
                        input int sh, input logic [63:0] sw);
    curM64 = m64; curPHit = ph; curPW1 = pw; curSHit = sh; curSW1 = sw;
    @(negedge clk);
    reads = 0;
    mode64 = m64; segDesc = seg; userMode = usr; accKind = kind; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic finishCase(input string req, input logic [1:0] eCode,
                            input logic [63:0] eWord, input logic [2:0] eProt, input int eReads);
    while (!done) @(negedge clk);
    check(resCode == eCode, req, "code", 64'(resCode), 64'(eCode));
    check(pteWord == eWord, req, "word", pteWord, eWord);
    check(prot == eProt, req, "prot", 64'(prot), 64'(eProt));
    check(reads == eReads, req, "reads", 64'(reads), 64'(eReads));
    @(negedge clk);
    check(!done, "R1", "done pulse width", 64'(done), 64'd0);
  endtask

  typedef struct packed {
    logic        m64;
    logic [31:0] seg;
    logic        user;
    logic [1:0]  kind;
    logic [3:0]  pHit;
    logic [63:0] pW1;
    logic [3:0]  sHit;
    logic [63:0] sW1;
    logic [1:0]  code;
    logic [2:0]  prot;
    logic [4:0]  reads;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 32'h0,         1'b0, 2'd0, 4'd2, 64'h2,                  4'd8, 64'h0,                  2'b00, 3'b111, 5'd4},  // R7 key0 pp2
    '{1'b0, 32'h2000_0000, 1'b1, 2'd1, 4'd0, 64'h1,                  4'd8, 64'h0,                  2'b10, 3'b101, 5'd10}, // R5 R9 deny kept
    '{1'b0, 32'h2000_0000, 1'b1, 2'd1, 4'd0, 64'h1,                  4'd5, 64'h2,                  2'b00, 3'b111, 5'd9},  // R5 secondary grants
    '{1'b0, 32'h4000_0000, 1'b1, 2'd0, 4'd8, 64'h0,                  4'd8, 64'h0,                  2'b11, 3'b000, 5'd16}, // R12 R6 key0
    '{1'b0, 32'h4000_0000, 1'b0, 2'd0, 4'd1, 64'h0,                  4'd7, 64'h3,                  2'b00, 3'b101, 5'd12}, // R6 key1 pp0
    '{1'b0, 32'h0,         1'b0, 2'd2, 4'd3, 64'h3,                  4'd8, 64'h0,                  2'b00, 3'b101, 5'd5},  // R9 fetch
    '{1'b1, 32'h0,         1'b0, 2'd2, 4'd4, 64'h6,                  4'd8, 64'h0,                  2'b10, 3'b011, 5'd14}, // R8 nx bit
    '{1'b1, 32'h0,         1'b0, 2'd2, 4'd0, 64'h8,                  4'd1, 64'h0,                  2'b00, 3'b111, 5'd5},  // R8 guarded
    '{1'b1, 32'h0,         1'b0, 2'd0, 4'd6, 64'h8000_0000_0000_0002, 4'd8, 64'h0,                 2'b00, 3'b101, 5'd8},  // R6 pp6
    '{1'b1, 32'h2000_0000, 1'b1, 2'd0, 4'd7, 64'h8000_0000_0000_0002, 4'd2, 64'h8000_0000_0000_0003, 2'b10, 3'b100, 5'd13}, // R7 pp6 pp7
    '{1'b1, 32'h0,         1'b0, 2'd1, 4'd5, 64'h8000_0000_0000_0001, 4'd8, 64'h0,                 2'b10, 3'b100, 5'd15}, // R7 pp5
    '{1'b1, 32'h2000_0000, 1'b1, 2'd1, 4'd0, 64'hA,                  4'd8, 64'h0,                  2'b00, 3'b011, 5'd2},  // R3 64-bit store
    '{1'b0, 32'h2000_0000, 1'b1, 2'd0, 4'd1, 64'h0000_0000_1234_5003, 4'd8, 64'h0,                 2'b00, 3'b101, 5'd3},  // R3 upper ignored
    '{1'b0, 32'h2000_0000, 1'b1, 2'd3, 4'd4, 64'h1,                  4'd8, 64'h0,                  2'b00, 3'b101, 5'd6},  // R9 kind3 load
    '{1'b0, 32'h0,         1'b0, 2'd2, 4'd2, 64'hE,                  4'd8, 64'h0,                  2'b00, 3'b111, 5'd4}   // R8 32-bit ignores bits 2/3
  };

  initial begin
    #(CLK_NS * 100000);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nTests + 1, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!done, "R1", "reset done", 64'(done), 64'd0);
    check(!memReq, "R2", "reset memReq", 64'(memReq), 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    check(!memReq, "R2", "idle memReq", 64'(memReq), 64'd0);

    // table walk: R3 R4 R5 R6 R7 R8 R9 R12
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      logic [63:0] eWord;
      v = VECS[i];
      if (v.sHit < 8) eWord = v.sW1;
      else if (v.pHit < 8) eWord = v.pW1;
      else eWord = '0;
      if (!v.m64) eWord = {32'b0, eWord[31:0]};
      launch(v.m64, v.seg, v.user, v.kind, int'(v.pHit), v.pW1, int'(v.sHit), v.sW1);
      finishCase($sformatf("R4 vec%0d", i), v.code, eWord, v.prot, int'(v.reads));
    end

    // R10 direct-store bypass
    launch(1'b0, 32'h8000_0000, 1'b0, 2'd0, 0, 64'h2, 8, 64'h0);
    finishCase("R10", 2'b01, 64'h0, 3'b000, 0);
    // R10 priority over no-execute fetch
    launch(1'b0, 32'h9000_0000, 1'b0, 2'd2, 0, 64'h2, 8, 64'h0);
    finishCase("R10 over R11", 2'b01, 64'h0, 3'b000, 0);
    // R11 fetch from no-execute segment
    launch(1'b1, 32'h1000_0000, 1'b0, 2'd2, 0, 64'h2, 8, 64'h0);
    finishCase("R11", 2'b10, 64'h0, 3'b000, 0);
    // R8 no-execute segment, load still looks up, X cleared
    launch(1'b0, 32'h1000_0000, 1'b0, 2'd0, 0, 64'h2, 8, 64'h0);
    finishCase("R8 seg nx load", 2'b00, 64'h2, 3'b011, 2);

    // R1 start while busy is ignored
    launch(1'b0, 32'h0, 1'b0, 2'd0, 2, 64'h2, 8, 64'h0);
    @(negedge clk);
    segDesc = 32'h8000_0000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    finishCase("R1 busy start", 2'b00, 64'h2, 3'b111, 4);

    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule